// File: doc/BRIEF.md
# Cascaded Serial DAC Loader

This block is the host side of a chain of 12-bit serial converters whose shift-register outputs are wired to the data inputs of the next device. The controller accepts one code per device as a single parallel vector together with a one-cycle start request. It streams every bit of every code over one data line, most significant bit first, with the code for the farthest device leading. It then lowers one shared active-low update strobe so that all converters copy their shift registers into their output registers in the same instant.

The serial clock is made from the system clock by a half-period divider. Data moves only on the falling serial-clock edge, so the devices always sample a settled line on the rising edge. The strobe stays high during the whole shift phase, because the device output register is transparent while the strobe is low and would otherwise show partial data. The strobe is held low for a programmed number of system cycles. The divider and the strobe length are checked at elaboration against a 1.4 MHz serial clock ceiling and a 150 ns strobe minimum for the given system clock frequency. `busy_o` covers the whole operation, and `done_o` flags its end.

Top module: `dac_chain_loader`

## Requirements
- R1: After reset, and whenever idle, `sclk_o` is 0, `load_n_o` is 1, `sdata_o` is 0, `busy_o` is 0 and `done_o` is 0.
- R2: Device k's code is `codes_i[k*12 +: 12]`, and device 0 takes the data line directly. The vector goes out from bit N*12-1 down to bit 0, so once the strobe falls every device holds and latches its own code (4095 full scale, 0 zero scale).
- R3: `sdata_o` changes only while `sclk_o` is low, and never in the same cycle that `sclk_o` rises.
- R4: During a transfer, every high and every low phase of `sclk_o` lasts exactly HALF_DIV system cycles. The first low phase counts from the cycle in which `busy_o` rises.
- R5: Each transfer has exactly N_DEV*12 rising edges of `sclk_o`, and all of them come before `load_n_o` falls.
- R6: `load_n_o` stays high while bits shift. It falls in the same cycle as the last falling edge of `sclk_o`, and `sclk_o` stays low while `load_n_o` is low.
- R7: `load_n_o` stays low for exactly STROBE_CYC system cycles.
- R8: `busy_o` is high for exactly N_DEV*24*HALF_DIV + STROBE_CYC + 1 cycles, starting the cycle after start is accepted. `done_o` is high for one cycle, the cycle after `load_n_o` returns high, and `busy_o` is low in that cycle.
- R9: A start request, or a change to `codes_i`, while `busy_o` is high has no effect on the running transfer: the latched codes, edge count and busy length stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled when idle |
| codes_i | input | N_DEV*12 | One 12-bit code per device, device 0 in the low bits |
| sclk_o | output | 1 | Serial clock to all devices |
| sdata_o | output | 1 | Serial data to device 0 |
| load_n_o | output | 1 | Shared active-low update strobe |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer flag |

## Verification
The assertions assume that `start_i` is a synchronous level sampled at the system clock and that `rst` is held for at least one edge. They also assume no outside agent drives the serial lines, so every phase and strobe length they measure comes from the block alone. The stimulus raises `start_i` for one cycle from idle, between edges, and raises it again only in the deliberate mid-transfer case. Each transfer is allowed to reach `done_o` before the next one begins, so the device model sees full frames only.

// File: rtl/dac_chain_pkg.sv
package dac_chain_pkg;
  localparam int unsigned DAC_CODE_W = 12;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_STROBE = 2'd2,
    ST_FIN    = 2'd3
  } load_state_t;
endpackage

// File: rtl/dac_half_tick.sv
module dac_half_tick #(
  parameter int unsigned HALF_DIV = 90
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CNT_W = $clog2(HALF_DIV + 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
  parameter int unsigned FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] data_i,
  input  logic               shift_i,
  output logic               msb_o
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
    end else if (load_i) begin
      frame_q <= data_i;
    end else if (shift_i) begin
      frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign msb_o = frame_q[FRAME_W-1];
endmodule

// File: rtl/dac_load_seq.sv
module dac_load_seq
  import dac_chain_pkg::*;
#(
  parameter int unsigned FRAME_W    = 24,
  parameter int unsigned STROBE_CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic tick_i,
  output logic run_o,
  output logic load_o,
  output logic shift_o,
  output logic sclk_o,
  output logic load_n_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned BIT_W  = $clog2(FRAME_W + 1);
  localparam int unsigned HOLD_W = $clog2(STROBE_CYC + 1);

  load_state_t       state_q;
  logic [BIT_W-1:0]  bit_q;
  logic [HOLD_W-1:0] hold_q;
  logic              sclk_q, load_n_q, busy_q, done_q;

  assign run_o   = (state_q == ST_SHIFT);
  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign shift_o = run_o && tick_i && sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      hold_q   <= '0;
      sclk_q   <= 1'b0;
      load_n_q <= 1'b1;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SHIFT;
            busy_q  <= 1'b1;
            bit_q   <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick_i) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == BIT_W'(FRAME_W - 1)) begin
                state_q  <= ST_STROBE;
                load_n_q <= 1'b0;
                hold_q   <= '0;
              end else begin
                bit_q <= bit_q + 1'b1;
              end
            end
          end
        end
        ST_STROBE: begin
          if (hold_q == HOLD_W'(STROBE_CYC - 1)) begin
            load_n_q <= 1'b1;
            state_q  <= ST_FIN;
          end else begin
            hold_q <= hold_q + 1'b1;
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o   = sclk_q;
  assign load_n_o = load_n_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/dac_chain_loader.sv
module dac_chain_loader
  import dac_chain_pkg::*;
#(
  parameter int unsigned N_DEV         = 2,
  parameter int unsigned SYS_HZ        = 250_000_000,
  parameter int unsigned HALF_DIV      = 90,
  parameter int unsigned STROBE_CYC    = 40,
  parameter int unsigned MAX_SCLK_HZ   = 1_400_000,
  parameter int unsigned MIN_STROBE_NS = 150
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic [N_DEV*DAC_CODE_W-1:0] codes_i,
  output logic                        sclk_o,
  output logic                        sdata_o,
  output logic                        load_n_o,
  output logic                        busy_o,
  output logic                        done_o
);
  localparam int unsigned FRAME_W = N_DEV * DAC_CODE_W;
  localparam longint SCLK_NEED  = longint'(SYS_HZ);
  localparam longint SCLK_ALLOW = 2 * longint'(HALF_DIV) * longint'(MAX_SCLK_HZ);
  localparam longint STB_HAVE   = longint'(STROBE_CYC) * 64'd1_000_000_000;
  localparam longint STB_NEED   = longint'(MIN_STROBE_NS) * longint'(SYS_HZ);

  if (SCLK_NEED > SCLK_ALLOW) begin : g_sclk_limit
    $error("dac_chain_loader: HALF_DIV too small for the serial clock ceiling");
  end
  if (STB_HAVE < STB_NEED) begin : g_strobe_limit
    $error("dac_chain_loader: STROBE_CYC too small for the minimum strobe width");
  end

  logic run, tick, load, shift;

  dac_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .tick_o (tick)
  );

  dac_frame_shifter #(.FRAME_W(FRAME_W)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .data_i  (codes_i),
    .shift_i (shift),
    .msb_o   (sdata_o)
  );

  dac_load_seq #(.FRAME_W(FRAME_W), .STROBE_CYC(STROBE_CYC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .tick_i   (tick),
    .run_o    (run),
    .load_o   (load),
    .shift_o  (shift),
    .sclk_o   (sclk_o),
    .load_n_o (load_n_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );
endmodule

// File: rtl/dac_chain_chk.sv
module dac_chain_chk #(
  parameter int unsigned FRAME_W    = 24,
  parameter int unsigned HALF_DIV   = 90,
  parameter int unsigned STROBE_CYC = 40
) (
  input logic clk,
  input logic rst,
  input logic sclk_o,
  input logic sdata_o,
  input logic load_n_o,
  input logic busy_o,
  input logic done_o
);
  logic        prev_sclk, prev_busy, prev_ln;
  int unsigned phase_run, low_run, rises;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_sclk <= 1'b0;
      prev_busy <= 1'b0;
      prev_ln   <= 1'b1;
      phase_run <= 0;
      low_run   <= 0;
      rises     <= 0;
    end else begin
      prev_sclk <= sclk_o;
      prev_busy <= busy_o;
      prev_ln   <= load_n_o;
      phase_run <= ((sclk_o != prev_sclk) || (busy_o && !prev_busy)) ? 1 : phase_run + 1;
      low_run   <= load_n_o ? 0 : (prev_ln ? 1 : low_run + 1);
      if (busy_o && !prev_busy) rises <= 0;
      else if (sclk_o && !prev_sclk) rises <= rises + 1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!sclk_o && load_n_o && !sdata_o)); // R1
  AST_DATA_SETTLED: assert property (@(posedge clk) disable iff (rst)
    sclk_o |-> $stable(sdata_o)); // R3
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (sclk_o != prev_sclk) |-> (phase_run == HALF_DIV)); // R4
  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!load_n_o && prev_ln) |-> (rises == FRAME_W)); // R5
  AST_STROBE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !load_n_o |-> !sclk_o); // R6
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (load_n_o && !prev_ln) |-> (low_run == STROBE_CYC)); // R7
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (load_n_o && !prev_ln) |=> (done_o && !busy_o)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R8
endmodule

bind dac_chain_loader dac_chain_chk #(
  .FRAME_W    (N_DEV * dac_chain_pkg::DAC_CODE_W),
  .HALF_DIV   (HALF_DIV),
  .STROBE_CYC (STROBE_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sclk_o   (sclk_o),
  .sdata_o  (sdata_o),
  .load_n_o (load_n_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/dac_chain_loader_bench.sv
`timescale 1ns/1ps
module dac_chain_loader_bench;
  localparam int N   = 2;
  localparam int CW  = 12;
  localparam int W   = N * CW;
  localparam int H   = 90;
  localparam int STB = 40;
  localparam int BUSY_LEN = W * 2 * H + STB + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [W-1:0] codes_i = '0;
  logic sclk_o, sdata_o, load_n_o, busy_o, done_o;

  always #2 clk = ~clk;

  dac_chain_loader #(.N_DEV(N), .HALF_DIV(H), .STROBE_CYC(STB)) u_dac_chain_loader (
    .clk(clk), .rst(rst), .start_i(start_i), .codes_i(codes_i),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .load_n_o(load_n_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device chain model: 12-bit shift registers plus low-transparent latches
  logic [CW-1:0] dev_sr  [N];
  logic [CW-1:0] dev_lat [N];
  initial for (int k = 0; k < N; k++) begin dev_sr[k] = '0; dev_lat[k] = '0; end

  always @(posedge sclk_o) begin
    dev_sr[0] <= {dev_sr[0][CW-2:0], sdata_o};
    for (int k = 1; k < N; k++) dev_sr[k] <= {dev_sr[k][CW-2:0], dev_sr[k-1][CW-1]};
  end
  always @(negedge clk) if (!load_n_o) for (int k = 0; k < N; k++) dev_lat[k] = dev_sr[k];

  // timing monitor, sampled between edges
  logic p_sclk = 0, p_sdata = 0, p_ln = 1, pp_ln = 1, p_busy = 0;
  int run_len = 0, hmin = 0, hmax = 0, rise_cnt = 0, rise_at_fall = 0;
  int low_cnt = 0, busy_cnt = 0, done_cnt = 0, done_bad = 0;
  int data_viol = 0, stb_viol = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (busy_o) busy_cnt++;
      if (sclk_o && !p_sclk) rise_cnt++;
      if (sclk_o && (sdata_o != p_sdata)) data_viol++;
      if (!load_n_o) begin
        low_cnt++;
        if (sclk_o) stb_viol++;
        if (p_ln) rise_at_fall = rise_cnt;
      end
      if (busy_o && load_n_o && p_ln && sclk_o == p_sclk && rise_cnt == W && !sclk_o && low_cnt == 0 && run_len > H) stb_viol++;
      if (done_o) begin
        done_cnt++;
        if (!(p_ln && !pp_ln) || busy_o) done_bad++;
      end
      if (sclk_o != p_sclk) begin
        if (run_len < hmin) hmin = run_len;
        if (run_len > hmax) hmax = run_len;
        run_len = 1;
      end else if (busy_o && !p_busy) run_len = 1;
      else run_len++;
    end
    pp_ln = p_ln; p_ln = load_n_o; p_sclk = sclk_o; p_sdata = sdata_o; p_busy = busy_o;
  end

  task automatic xfer(input logic [W-1:0] c, input bit poke);
    @(posedge clk); #1;
    hmin = 1 << 30; hmax = 0; rise_cnt = 0; rise_at_fall = -1; low_cnt = 0;
    busy_cnt = 0; done_cnt = 0; done_bad = 0; data_viol = 0; stb_viol = 0;
    codes_i = c; start_i = 1'b1;
    @(posedge clk); #1; start_i = 1'b0;
    if (poke) begin
      repeat (1500) @(posedge clk); #1;
      codes_i = ~c; start_i = 1'b1;   // R9: ignored while busy
      @(posedge clk); #1; start_i = 1'b0;
    end
    for (int g = 0; g < 20000 && done_cnt == 0; g++) @(posedge clk);
    repeat (3) @(posedge clk); #1;
    for (int k = 0; k < N; k++)
      chk(dev_lat[k] == c[k*CW +: CW], poke ? "R9 latched code" : "R2 latched code",
          dev_lat[k], c[k*CW +: CW]);
    chk(data_viol == 0, "R3 data moved with clock high", data_viol, 0);
    chk(hmin == H && hmax == H, "R4 half period", (hmin == H) ? hmax : hmin, H);
    chk(rise_cnt == W, "R5 rising edges", rise_cnt, W);
    chk(rise_at_fall == W, "R5 R6 edges before strobe", rise_at_fall, W);
    chk(stb_viol == 0, "R6 clock high under strobe", stb_viol, 0);
    chk(low_cnt == STB, "R7 strobe width", low_cnt, STB);
    chk(busy_cnt == BUSY_LEN, poke ? "R9 busy length" : "R8 busy length", busy_cnt, BUSY_LEN);
    chk(done_cnt == 1 && done_bad == 0, "R8 done pulse", done_cnt + 10 * done_bad, 1);
    chk(!busy_o && !sclk_o && load_n_o && !sdata_o, "R1 idle after transfer",
        {busy_o, sclk_o, load_n_o, sdata_o}, 4'b0010);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired after %0d checks", checks);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk); #1;
    rst = 1'b0;
    @(posedge clk); #1;
    chk(sclk_o == 1'b0,   "R1 reset sclk",   sclk_o, 0);
    chk(load_n_o == 1'b1, "R1 reset strobe", load_n_o, 1);
    chk(sdata_o == 1'b0,  "R1 reset data",   sdata_o, 0);
    chk(busy_o == 1'b0,   "R1 reset busy",   busy_o, 0);
    chk(done_o == 1'b0,   "R1 reset done",   done_o, 0);

    xfer('0, 1'b0);                          // zero scale everywhere
    xfer('1, 1'b0);                          // full scale everywhere
    xfer({12'd4095, 12'd0}, 1'b0);           // far full, near zero
    xfer({12'd0, 12'd4095}, 1'b0);
    for (int b = 0; b < W; b++) xfer(W'(1) << b, 1'b0);  // R2 walking one
    xfer({12'hA5C, 12'h3B1}, 1'b1);          // R9 start and new codes mid-transfer

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule